// File: doc/BRIEF.md
# Multi-Port Cell Rate Pacing Scheduler

This block decides when cells may be sent toward up to 31 physical ports. Four programmable rate timers count a slow external tick. Each timer reloads from a programmed start value, and every expiry opens one cell opportunity at that timer's rate. In basic mode, ports 0 to 3 each own one timer and the remaining ports are never paced. In expanded mode, the four timers act as rate groups, and a two-bit group field per port ties any port to any timer.

For each port, the block tracks how many opportunities have come due but are still waiting for a cell-sent acknowledge. This backlog saturates at seven. When a port's backlog reaches seven, a sticky underrun status bit is set for that port. A masked OR of the status bits drives one interrupt line. Ports with a nonzero backlog are shown on a due vector, and a fixed lowest-index-first selector names the port to serve next. Software programs the timers, the mode, the group map and the mask through a simple register write/read port.

Top module: `cell_pacer`

## Requirements
- R1: After reset, every register reads 0, `due_vec` is 0, and `serve_valid` and `irq` are 0.
- R2: Register map (4-bit address, 32-bit data, read data valid one cycle after `rd_en`). 0 = mode, in bit 0. 1 = group low, where port p (0..15) uses bits 2p+1:2p. 2 = group high, where port p (16..30) uses bits 2(p-16)+1:2(p-16). 3 = underrun status, one bit per port. 4 = interrupt mask, one bit per port. 8..11 = start value of timer 0..3, in the low 8 bits.
- R3: In basic mode (mode bit 0), port n for n < 4 is paced only by timer n. Ports 4 and above never build a backlog, and the group fields have no effect.
- R4: In expanded mode (mode bit 1), each port is paced by the timer its group field selects.
- R5: A port's backlog rises by one on each expiry of its timer and falls by one on each acknowledge naming it (`ack_valid` with `ack_port`). It stays at 7 on further expiries and stays at 0 on further acknowledges. An expiry and an acknowledge in the same cycle leave it unchanged.
- R6: Writing a timer's start value N also loads its count. With N > 0, the timer expires on every (N+1)-th tick, and the first expiry comes N+1 ticks after the write. N = 0 stops the timer.
- R7: `due_vec[p]` is 1 exactly while port p's backlog is nonzero. One cycle later, `serve_valid`/`serve_port` name the lowest-numbered due port, or `serve_valid` is 0 when no port is due.
- R8: The status bit of a port is set when an expiry raises its backlog to 7.
- R9: Status bits are sticky. Writing 1 to a bit at address 3 clears it, and writing 0 leaves it. A set event in the same cycle as the clear wins.
- R10: `irq` equals the OR of (status AND mask), registered one cycle behind them.
- R11: `tick_in` is asynchronous and is synchronised to `clk`. Each rising edge counts as exactly one tick, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| tick_in | input | 1 | Slow asynchronous rate tick |
| ack_valid | input | 1 | A cell was sent |
| ack_port | input | 5 | Port the sent cell belonged to |
| due_vec | output | 31 | Per-port nonzero-backlog flags |
| serve_valid | output | 1 | Some port is due |
| serve_port | output | 5 | Lowest-numbered due port |
| irq | output | 1 | Masked underrun interrupt |

## Verification
A timer expiry and a cell-sent acknowledge can both land on the same port's backlog in one clock. The bench arranges this by raising the acknowledge in the exact cycle where the synchronised tick pulse meets a timer at zero. The backlog is then read out by counting acknowledges until the port's due flag drops. The count must equal the backlog from before that cycle, not one more or one less.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 32;
  localparam int NUM_TIMERS  = 4;
  localparam int GRP_W       = 2;
  localparam int TIDX_W      = 2;
  localparam int LO_PORTS    = DATA_W / GRP_W;

  localparam logic [ADDR_W-1:0] REG_MODE    = 4'd0;
  localparam logic [ADDR_W-1:0] REG_GSEL_LO = 4'd1;
  localparam logic [ADDR_W-1:0] REG_GSEL_HI = 4'd2;
  localparam logic [ADDR_W-1:0] REG_STATUS  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_MASK    = 4'd4;
  localparam logic [ADDR_W-1:0] REG_TINIT   = 4'd8;
endpackage

// File: rtl/pacer_tick_sync.sv
module pacer_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic tick_pulse
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], tick_in};
  end

  // one pulse per rising edge of the synchronised tick
  assign tick_pulse = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/pacer_rate_timer.sv
module pacer_rate_timer #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  input  logic [TIMER_W-1:0] start_val,
  output logic               expire
);
  logic [TIMER_W-1:0] cnt;
  logic               running;

  assign running = (start_val != '0);
  assign expire  = tick && running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (tick && running) cnt <= (cnt == '0) ? start_val : cnt - 1'b1;
  end
endmodule

// File: rtl/pacer_lag_counter.sv
module pacer_lag_counter #(
  parameter int LAG_MAX = 7,
  parameter int LAG_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [LAG_W-1:0] lag,
  output logic             due,
  output logic             underrun
);
  localparam logic [LAG_W-1:0] TOP  = LAG_W'(LAG_MAX);
  localparam logic [LAG_W-1:0] NEAR = LAG_W'(LAG_MAX - 1);

  always_ff @(posedge clk) begin
    if (rst) lag <= '0;
    else begin
      case ({inc, dec})
        2'b10:   if (lag != TOP) lag <= lag + 1'b1;
        2'b01:   if (lag != '0)  lag <= lag - 1'b1;
        default: lag <= lag;
      endcase
    end
  end

  assign due      = (lag != '0);
  assign underrun = inc && !dec && (lag == NEAR);
endmodule

// File: rtl/cell_pacer.sv
module cell_pacer
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS   = 31,
  parameter int TIMER_W     = 8,
  parameter int LAG_MAX     = 7,
  parameter int SYNC_STAGES = 2,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int LAG_W      = $clog2(LAG_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 tick_in,
  input  logic                 ack_valid,
  input  logic [PORT_W-1:0]    ack_port,
  output logic [NUM_PORTS-1:0] due_vec,
  output logic                 serve_valid,
  output logic [PORT_W-1:0]    serve_port,
  output logic                 irq
);
  logic                                 mode_q;
  logic [NUM_TIMERS-1:0][TIMER_W-1:0]   tinit_q;
  logic [NUM_PORTS-1:0][GRP_W-1:0]      grp_q;
  logic [NUM_PORTS-1:0]                 status_q;
  logic [NUM_PORTS-1:0]                 mask_q;
  logic [NUM_PORTS-1:0]                 clr_bits;
  logic [NUM_PORTS-1:0]                 urun_evt;
  logic [NUM_PORTS-1:0]                 port_inc;
  logic [NUM_PORTS-1:0]                 port_dec;
  logic [NUM_PORTS-1:0][LAG_W-1:0]      lag_w;
  logic [NUM_TIMERS-1:0]                expire;
  logic [NUM_TIMERS-1:0]                tload;
  logic                                 tick;
  logic [DATA_W-1:0]                    gsel_lo, gsel_hi, rd_next;
  logic                                 pick_v;
  logic [PORT_W-1:0]                    pick;

  pacer_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick_in(tick_in), .tick_pulse(tick)
  );

  // ---------------- rate timers ----------------
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assign tload[t] = wr_en && (wr_addr == (REG_TINIT + ADDR_W'(t)));
    pacer_rate_timer #(.TIMER_W(TIMER_W)) u_tmr (
      .clk(clk), .rst(rst), .tick(tick), .load(tload[t]),
      .load_val(wr_data[TIMER_W-1:0]), .start_val(tinit_q[t]),
      .expire(expire[t])
    );
  end

  // ---------------- control registers ----------------
  assign clr_bits = (wr_en && wr_addr == REG_STATUS) ? wr_data[NUM_PORTS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      tinit_q  <= '0;
      grp_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_bits) | urun_evt;
      if (wr_en) begin
        if (wr_addr == REG_MODE) mode_q <= wr_data[0];
        if (wr_addr == REG_MASK) mask_q <= wr_data[NUM_PORTS-1:0];
        for (int t = 0; t < NUM_TIMERS; t++)
          if (tload[t]) tinit_q[t] <= wr_data[TIMER_W-1:0];
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (p < LO_PORTS) begin
            if (wr_addr == REG_GSEL_LO) grp_q[p] <= wr_data[GRP_W*p +: GRP_W];
          end else begin
            if (wr_addr == REG_GSEL_HI)
              grp_q[p] <= wr_data[GRP_W*((p >= LO_PORTS) ? p - LO_PORTS : 0) +: GRP_W];
          end
        end
      end
    end
  end

  // ---------------- per-port backlog ----------------
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p < NUM_TIMERS) begin : g_basic
      assign port_inc[p] = mode_q ? expire[grp_q[p]] : expire[p];
    end else begin : g_grp_only
      assign port_inc[p] = mode_q && expire[grp_q[p]];
    end
    assign port_dec[p] = ack_valid && (ack_port == PORT_W'(p));

    pacer_lag_counter #(.LAG_MAX(LAG_MAX), .LAG_W(LAG_W)) u_lag (
      .clk(clk), .rst(rst), .inc(port_inc[p]), .dec(port_dec[p]),
      .lag(lag_w[p]), .due(due_vec[p]), .underrun(urun_evt[p])
    );
  end

  // ---------------- service selection ----------------
  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (due_vec[p]) begin
        pick_v = 1'b1;
        pick   = PORT_W'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      serve_valid <= 1'b0;
      serve_port  <= '0;
      irq         <= 1'b0;
    end else begin
      serve_valid <= pick_v;
      serve_port  <= pick;
      irq         <= |(status_q & mask_q);
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    gsel_lo = '0;
    gsel_hi = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (p < LO_PORTS) gsel_lo[GRP_W*p +: GRP_W] = grp_q[p];
      else gsel_hi[GRP_W*((p >= LO_PORTS) ? p - LO_PORTS : 0) +: GRP_W] = grp_q[p];
    end
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      REG_MODE:    rd_next[0] = mode_q;
      REG_GSEL_LO: rd_next = gsel_lo;
      REG_GSEL_HI: rd_next = gsel_hi;
      REG_STATUS:  rd_next[NUM_PORTS-1:0] = status_q;
      REG_MASK:    rd_next[NUM_PORTS-1:0] = mask_q;
      default: begin
        if (rd_addr[ADDR_W-1:TIDX_W] == REG_TINIT[ADDR_W-1:TIDX_W])
          rd_next[TIMER_W-1:0] = tinit_q[rd_addr[TIDX_W-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 31,
  parameter int LAG_MAX   = 7,
  parameter int LAG_W     = 3,
  parameter int PORT_W    = 5
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            mode,
  input logic [NUM_PORTS-1:0][LAG_W-1:0] lag,
  input logic [NUM_PORTS-1:0]            status,
  input logic [NUM_PORTS-1:0]            mask,
  input logic                            irq,
  input logic [NUM_PORTS-1:0]            due_vec,
  input logic                            serve_valid,
  input logic [PORT_W-1:0]               serve_port,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               wr_addr
);
  localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);

  // R7: served port was due in the previous cycle
  a_r7_serve_was_due: assert property (@(posedge clk) disable iff (rst)
    serve_valid |-> ((($past(due_vec)) >> serve_port) & ONE) != '0);

  // R7: no lower-numbered port was due
  a_r7_serve_lowest: assert property (@(posedge clk) disable iff (rst)
    serve_valid |-> ($past(due_vec) & ((ONE << serve_port) - ONE)) == '0);

  // R7: idle only when nothing was due
  a_r7_serve_idle: assert property (@(posedge clk) disable iff (rst)
    !serve_valid |-> $past(due_vec) == '0);

  // R9: status bits never drop without a status write
  a_r9_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == REG_STATUS) |=> ((status & $past(status)) == $past(status)));

  // R10: interrupt follows masked status one cycle later
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq == |($past(status) & $past(mask)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R5: no wrap at either end
    a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
      (lag[p] == LAG_W'(LAG_MAX)) |=> (lag[p] >= LAG_W'(LAG_MAX - 1)));
    a_r5_no_wrap_floor: assert property (@(posedge clk) disable iff (rst)
      (lag[p] == '0) |=> (lag[p] <= LAG_W'(1)));
    if (p >= NUM_TIMERS) begin : g_hi
      // R3: high ports never grow in basic mode
      a_r3_basic_high_idle: assert property (@(posedge clk) disable iff (rst)
        !mode |=> (lag[p] <= $past(lag[p])));
    end
  end
endmodule

bind cell_pacer pacer_checker #(
  .NUM_PORTS(NUM_PORTS), .LAG_MAX(LAG_MAX), .LAG_W(LAG_W), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .lag(lag_w), .status(status_q),
  .mask(mask_q), .irq(irq), .due_vec(due_vec), .serve_valid(serve_valid),
  .serve_port(serve_port), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_cell_pacer.sv
module sim_cell_pacer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_in = 1'b0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_port = '0;
  logic [30:0] due_vec;
  logic        serve_valid;
  logic [4:0]  serve_port;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cell_pacer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tick_in(tick_in),
    .ack_valid(ack_valid), .ack_port(ack_port), .due_vec(due_vec),
    .serve_valid(serve_valid), .serve_port(serve_port), .irq(irq)
  );

  // init, ticks, expected backlog, expected underrun (timer 0 / port 0, basic mode)
  localparam int VEC [7][4] = '{
    '{1,  4, 2, 0}, '{2,  7, 2, 0}, '{0,  5, 0, 0}, '{1, 18, 7, 1},
    '{3,  8, 2, 0}, '{1, 14, 7, 1}, '{1, 12, 6, 0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic tick_once(input bit with_ack, input logic [4:0] p);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk); if (with_ack) begin ack_valid = 1'b1; ack_port = p; end
    @(negedge clk); ack_valid = 1'b0;
    @(negedge clk); tick_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once(1'b0, 5'd0);
  endtask

  task automatic ack(input logic [4:0] p);
    @(negedge clk); ack_valid = 1'b1; ack_port = p;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  // drains a port and returns how many acknowledges it took
  task automatic drain(input logic [4:0] p, output int n);
    n = 0;
    while (due_vec[p] && n < 10) begin ack(p); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 due_vec", {1'b0, due_vec}, 32'h0);
    check("R1 serve_valid", {31'b0, serve_valid}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'd0, r);  check("R1 mode", r, 32'h0);
    rd(4'd3, r);  check("R1 status", r, 32'h0);
    rd(4'd8, r);  check("R1 timer0 start", r, 32'h0);

    // R6 R5 R8 table walk on port 0
    foreach (VEC[i]) begin
      wr(4'd8, VEC[i][0]);
      ticks(VEC[i][1]);
      drain(5'd0, n);
      check($sformatf("R6 R5 backlog vec%0d", i), n, VEC[i][2]);
      rd(4'd3, r);
      check($sformatf("R8 R9 status vec%0d", i), r, VEC[i][3]);
      if (VEC[i][3] != 0) begin
        check("R10 irq masked off", {31'b0, irq}, 32'h0);
        wr(4'd4, 32'h1);
        @(negedge clk);
        check("R10 irq enabled", {31'b0, irq}, 32'h1);
        wr(4'd3, 32'h0);
        rd(4'd3, r);  check("R9 write 0 keeps status", r, 32'h1);
        wr(4'd3, 32'h1);
        rd(4'd3, r);  check("R9 write 1 clears", r, 32'h0);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);
        wr(4'd4, 32'h0);
      end
    end

    // R5 expiry and acknowledge in the same cycle
    wr(4'd8, 32'd1);
    ticks(3);
    tick_once(1'b1, 5'd0);
    drain(5'd0, n);
    check("R5 same-cycle inc and dec", n, 1);

    // R5 acknowledge at zero does not wrap
    wr(4'd8, 32'd0);
    ack(5'd3);
    check("R5 ack at zero", {1'b0, due_vec}, 32'h0);
    wr(4'd11, 32'd1);
    ticks(2);
    drain(5'd3, n);
    check("R5 floor then one expiry", n, 1);
    wr(4'd11, 32'd0);

    // R11 long high tick counts once
    wr(4'd8, 32'd1);
    @(negedge clk); tick_in = 1'b1;
    repeat (20) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 held tick counted once", {1'b0, due_vec}, 32'h0);
    ticks(1);
    check("R11 next edge expires", {1'b0, due_vec}, 32'h1);
    drain(5'd0, n);

    // R3 basic mode ignores group map and high ports
    wr(4'd1, 32'h0000_0C00);      // port 5 -> group 3
    wr(4'd11, 32'd1);             // timer 3 running
    wr(4'd8, 32'd1);
    wr(4'd9, 32'd0);
    ticks(2);
    check("R3 only ports 0 and 3", {1'b0, due_vec}, 32'h9);
    drain(5'd0, n);
    drain(5'd3, n);
    wr(4'd11, 32'd0);

    // R4 R7 expanded mode with group map
    wr(4'd8, 32'd0);
    wr(4'd10, 32'd1);
    wr(4'd1, 32'h0020_0000);      // port 10 -> group 2
    wr(4'd2, 32'h2000_0000);      // port 30 -> group 2
    wr(4'd0, 32'h1);
    rd(4'd2, r);  check("R2 group high readback", r, 32'h2000_0000);
    rd(4'd10, r); check("R2 timer2 readback", r, 32'h1);
    ticks(2);
    check("R4 ports 10 and 30 due", {1'b0, due_vec}, 32'h4000_0400);
    check("R7 serve lowest", {27'b0, serve_port}, 32'd10);
    check("R7 serve valid", {31'b0, serve_valid}, 32'h1);
    ack(5'd10);
    @(negedge clk);
    check("R7 serve moves to 30", {27'b0, serve_port}, 32'd30);
    ack(5'd30);
    @(negedge clk);
    check("R7 serve idle", {31'b0, serve_valid}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule